// File: doc/BRIEF.md
# Centre-Aligned Complementary PWM Generator

This block produces three complementary pairs of gate-drive signals from one shared up/down counter. The counter sweeps a symmetric triangle from zero up to a programmable period value and back down to zero. Each channel compares the counter against its own duty value and keeps an internal level flag. The flag is set when the counter passes the duty value on the way up and cleared when it passes it on the way down, so every pulse sits symmetrically around the triangle peak. A positive-phase and a negative-phase output are taken from that flag. A programmable dead time holds back whichever output is being switched on, so the two switches of a pair are never on together.

Software writes the period, the dead time and the three duty values through a simple write port. Period and duty writes go to buffer registers. These are copied into the active registers at the valley of the triangle, or continuously while the block is stopped, so a cycle never runs with a mix of old and new settings. The dead-time value is captured only while the block is stopped. The block raises single-cycle event pulses at the peak and at the valley. It can also raise per-channel compare-match pulses, which a parameter enables for the one instance that needs them.

Top module: `cpwm_top`

## Requirements
- R1: While running with an active period P >= 1, `cnt_o` starts at 0 and steps by exactly one each clock: up to P, then down to 0, then up again. A full triangle lasts 2P clocks.
- R2: `peak_o` is high for exactly the one clock where the counter equals P. `valley_o` is high for exactly the one clock where the counter equals 0. Each fires once per triangle.
- R3: Write map on `wr_addr`: 0 = control, where bit 0 set means run; 1 = period; 2 = dead time, taken from the low DT_W bits of `wr_data`; 4 + i = duty buffer of channel i.
- R4: For a duty value C with 1 <= C < P, the channel flag is high for 2(P - C) clocks per triangle and is centred on the peak. The positive phase follows the flag and the negative phase follows its inverse.
- R5: An output of a pair turns on only after both outputs have been low for DT + 1 clocks, where DT is the dead-time value. In steady state the positive phase is high for 2(P - C) - DT - 1 clocks per triangle and the negative phase for 2C - DT - 1 clocks.
- R6: A duty value C >= P never matches, and the flag keeps its state. Because the flag is low at the valley, this gives a positive phase that stays off and a negative phase that is on for the whole triangle. A duty value of 0 also keeps the positive phase off.
- R7: When a flag pulse is no longer than DT + 1 clocks, the output it would turn on stays low for that pulse.
- R8: The positive and negative outputs of one pair are never high in the same clock.
- R9: With MATCH_EV = 1, `match_o[i]` pulses in every clock where the counter equals channel i's duty value C < P, which is twice per triangle for C >= 1. With MATCH_EV = 0, `match_o` stays 0.
- R10: Period and duty writes reach the active registers only at a valley or while stopped. A duty write made mid-triangle leaves the current triangle's pulse unchanged.
- R11: A dead-time write made while running has no effect until the block is stopped and started again.
- R12: After reset, and from the second clock after run is cleared, `cnt_o` is 0. From the first stopped clock, all phase outputs and event pulses are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select (see R3) |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current triangle counter value |
| pos_o | output | NCH | Positive-phase outputs, active high |
| neg_o | output | NCH | Negative-phase outputs, active high |
| peak_o | output | 1 | Pulse at the triangle peak |
| valley_o | output | 1 | Pulse at the triangle valley |
| match_o | output | NCH | Per-channel compare-match pulses |

## Verification
The bench builds two instances. Both use the default 16-bit counter, 8-bit dead time and three channels; one has match events enabled and the other has them disabled, so both variants of the event generate branch are exercised with the same stimulus. Periods of 5 and 20 keep each triangle short, so steady-state pulse widths can be counted over whole triangles. Dead times of 2, 6 and 10 cover the normal case, a change made while running, and a dead time wider than the shortest pulses. Duty values of 0, equal to the period and above the period reach the no-match corners.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;

    typedef enum logic {
        SLOPE_DOWN = 1'b0,
        SLOPE_UP   = 1'b1
    } slope_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } phase_pair_t;

    localparam int unsigned REG_CTRL      = 0;
    localparam int unsigned REG_PERIOD    = 1;
    localparam int unsigned REG_DEAD      = 2;
    localparam int unsigned REG_DUTY_BASE = 4;

    function automatic logic is_duty_sel(input int unsigned addr, input int unsigned ch);
        return addr == (REG_DUTY_BASE + ch);
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
`timescale 1ns/1ps
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DT_W   = 8,
    parameter int NCH    = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              valley,
    output logic              run_q,
    output logic [CNT_W-1:0]  period_act,
    output logic [DT_W-1:0]   dt_act,
    output logic [DT_W-1:0]   dt_reg,
    output logic [CNT_W-1:0]  cmp_act [NCH]
);

    logic [CNT_W-1:0] period_reg;
    logic [CNT_W-1:0] duty_buf [NCH];
    logic             reload;

    // Active values follow the buffers only at a valley or while stopped.
    assign reload = !run_q || valley;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= 1'b0;
            period_reg <= '0;
            dt_reg     <= '0;
        end else if (wr_en) begin
            case (int'(wr_addr))
                REG_CTRL:   run_q      <= wr_data[0];
                REG_PERIOD: period_reg <= wr_data;
                REG_DEAD:   dt_reg     <= wr_data[DT_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_act <= '0;
            dt_act     <= '0;
        end else begin
            if (reload) period_act <= period_reg;
            if (!run_q) dt_act     <= dt_reg;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst) begin
                duty_buf[g] <= '0;
                cmp_act[g]  <= '0;
            end else begin
                if (wr_en && is_duty_sel(int'(wr_addr), g)) duty_buf[g] <= wr_data;
                if (reload) cmp_act[g] <= duty_buf[g];
            end
        end
    end

endmodule

// File: rtl/cpwm_counter.sv
`timescale 1ns/1ps
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output slope_e           slope,
    output logic             peak,
    output logic             valley
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    // The valley clock is counted as the tail of the down slope, and the
    // peak clock as the top of the up slope.
    always_ff @(posedge clk) begin
        if (rst || !run || period == '0) begin
            cnt   <= '0;
            slope <= SLOPE_DOWN;
        end else if (slope == SLOPE_UP) begin
            if (cnt >= period) begin
                slope <= SLOPE_DOWN;
                cnt   <= cnt - STEP;
            end else begin
                cnt   <= cnt + STEP;
            end
        end else begin
            if (cnt == '0) begin
                slope <= SLOPE_UP;
                cnt   <= STEP;
            end else begin
                cnt   <= cnt - STEP;
            end
        end
    end

    assign peak   = run && (period != '0) && (slope == SLOPE_UP) && (cnt == period);
    assign valley = run && (cnt == '0);

endmodule

// File: rtl/cpwm_deadtime.sv
`timescale 1ns/1ps
module cpwm_deadtime
    import cpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            level,
    input  logic [DT_W-1:0] dt_act,
    input  logic [DT_W-1:0] dt_reg,
    output phase_pair_t     pair
);

    logic            prev;
    logic [DT_W-1:0] hold;
    logic            settled;

    // The clock where the level changes plus DT further clocks keep both
    // outputs off; any new change restarts the wait.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            hold <= '0;
        end else if (!run) begin
            prev <= 1'b0;
            hold <= dt_reg;
        end else begin
            prev <= level;
            if (level != prev)   hold <= dt_act;
            else if (hold != '0) hold <= hold - DT_W'(1);
        end
    end

    assign settled = run && (level == prev) && (hold == '0);

    always_comb begin
        pair.pos = settled &  level;
        pair.neg = settled & ~level;
    end

endmodule

// File: rtl/cpwm_channel.sv
`timescale 1ns/1ps
module cpwm_channel
    import cpwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DT_W     = 8,
    parameter bit MATCH_EV = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  slope_e           slope,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp,
    input  logic [DT_W-1:0]  dt_act,
    input  logic [DT_W-1:0]  dt_reg,
    output logic             flag,
    output phase_pair_t      pair,
    output logic             match_ev
);

    logic hit;

    // A compare value at or above the period never matches.
    assign hit = run && (cnt == cmp) && (cmp < period);

    always_ff @(posedge clk) begin
        if (rst || !run)  flag <= 1'b0;
        else if (hit)     flag <= (slope == SLOPE_UP);
    end

    if (MATCH_EV) begin : g_ev
        assign match_ev = hit;
    end else begin : g_no_ev
        assign match_ev = 1'b0;
    end

    cpwm_deadtime #(.DT_W(DT_W)) u_deadtime (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .level  (flag),
        .dt_act (dt_act),
        .dt_reg (dt_reg),
        .pair   (pair)
    );

endmodule

// File: rtl/cpwm_top.sv
`timescale 1ns/1ps
module cpwm_top
    import cpwm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DT_W     = 8,
    parameter int NCH      = 3,
    parameter int ADDR_W   = 3,
    parameter bit MATCH_EV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NCH-1:0]    pos_o,
    output logic [NCH-1:0]    neg_o,
    output logic              peak_o,
    output logic              valley_o,
    output logic [NCH-1:0]    match_o
);

    logic             run_q;
    logic [CNT_W-1:0] period_act;
    logic [DT_W-1:0]  dt_act;
    logic [DT_W-1:0]  dt_reg;
    logic [CNT_W-1:0] cmp_act [NCH];
    logic [CNT_W-1:0] cnt;
    slope_e           slope;
    logic [NCH-1:0]   flag_vec;
    phase_pair_t      pairs [NCH];

    cpwm_regs #(
        .CNT_W (CNT_W),
        .DT_W  (DT_W),
        .NCH   (NCH),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .valley    (valley_o),
        .run_q     (run_q),
        .period_act(period_act),
        .dt_act    (dt_act),
        .dt_reg    (dt_reg),
        .cmp_act   (cmp_act)
    );

    cpwm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .run   (run_q),
        .period(period_act),
        .cnt   (cnt),
        .slope (slope),
        .peak  (peak_o),
        .valley(valley_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cpwm_channel #(
            .CNT_W   (CNT_W),
            .DT_W    (DT_W),
            .MATCH_EV(MATCH_EV)
        ) u_channel (
            .clk     (clk),
            .rst     (rst),
            .run     (run_q),
            .cnt     (cnt),
            .slope   (slope),
            .period  (period_act),
            .cmp     (cmp_act[g]),
            .dt_act  (dt_act),
            .dt_reg  (dt_reg),
            .flag    (flag_vec[g]),
            .pair    (pairs[g]),
            .match_ev(match_o[g])
        );
        assign pos_o[g] = pairs[g].pos;
        assign neg_o[g] = pairs[g].neg;
    end

    assign cnt_o = cnt;

endmodule

// File: rtl/cpwm_checker.sv
`timescale 1ns/1ps
module cpwm_checker #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8,
    parameter int NCH   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] period_act,
    input logic [DT_W-1:0]  dt_act,
    input logic [CNT_W-1:0] cmp_act [NCH],
    input logic [NCH-1:0]   flag,
    input logic [NCH-1:0]   pos,
    input logic [NCH-1:0]   neg,
    input logic             peak,
    input logic             valley
);

    localparam int GAP_W = DT_W + 2;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (run && period_act != '0) |-> (cnt <= period_act));

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && period_act != '0 && $past(period_act) != '0)
        |-> (cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));

    p_peak_turn_r2: assert property (@(posedge clk) disable iff (rst)
        peak |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_peak_value_r2: assert property (@(posedge clk) disable iff (rst)
        peak |-> (cnt == period_act));

    p_valley_turn_r2: assert property (@(posedge clk) disable iff (rst)
        (valley && run && period_act != '0) |=> (cnt == CNT_W'(1) || !run));

    p_stop_cnt_r12: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    p_stop_out_r12: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pos == '0 && neg == '0 && !peak && !valley));

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        (pos & neg) == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic [GAP_W-1:0] gap;

        // Consecutive clocks with both outputs of the pair off.
        always_ff @(posedge clk) begin
            if (rst)                 gap <= '1;
            else if (pos[g] | neg[g]) gap <= '0;
            else if (gap != '1)      gap <= gap + GAP_W'(1);
        end

        p_dead_gap_r5: assert property (@(posedge clk) disable iff (rst)
            ($rose(pos[g]) || $rose(neg[g])) |-> (int'(gap) >= int'(dt_act) + 1));

        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (run && cmp_act[g] >= period_act) |=> $stable(flag[g]));

        p_set_at_cmp_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(flag[g]) |-> ($past(cnt) == $past(cmp_act[g])));
    end

endmodule

bind cpwm_top cpwm_checker #(
    .CNT_W(CNT_W),
    .DT_W (DT_W),
    .NCH  (NCH)
) u_cpwm_checker (
    .clk       (clk),
    .rst       (rst),
    .run       (run_q),
    .cnt       (cnt),
    .period_act(period_act),
    .dt_act    (dt_act),
    .cmp_act   (cmp_act),
    .flag      (flag_vec),
    .pos       (pos_o),
    .neg       (neg_o),
    .peak      (peak_o),
    .valley    (valley_o)
);

// File: tb/cpwm_top_bench.sv
`timescale 1ns/1ps
module cpwm_top_bench;

    localparam int CNT_W  = 16;
    localparam int NCH    = 3;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [CNT_W-1:0]  cnt_o, cnt_nm;
    logic [NCH-1:0]    pos_o, neg_o, match_o, pos_nm, neg_nm, match_nm;
    logic              peak_o, valley_o, peak_nm, valley_nm;

    always #2 clk = ~clk;

    cpwm_top u_cpwm_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .pos_o(pos_o), .neg_o(neg_o), .peak_o(peak_o),
        .valley_o(valley_o), .match_o(match_o)
    );

    cpwm_top #(.MATCH_EV(1'b0)) u_cpwm_top_nm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_nm), .pos_o(pos_nm), .neg_o(neg_nm), .peak_o(peak_nm),
        .valley_o(valley_nm), .match_o(match_nm)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int pos_n [NCH];
    int neg_n [NCH];
    int mt_n  [NCH];
    int mt_at [NCH];
    int cset  [NCH];
    int ovl_n, pk_n, vl_n, mt_nm_n;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // R3 register map: 0 control, 1 period, 2 dead time, 4+i duty of channel i.
    task automatic configure(input int p, input int dt, input int c0, input int c1, input int c2);
        write_reg(0, 0);
        write_reg(1, p);
        write_reg(2, dt);
        write_reg(4, c0);
        write_reg(5, c1);
        write_reg(6, c2);
        cset[0] = c0; cset[1] = c1; cset[2] = c2;
        @(negedge clk);
    endtask

    task automatic start_run();
        write_reg(0, 1);
    endtask

    task automatic next_valley();
        @(negedge clk);
        while (!valley_o) @(negedge clk);
    endtask

    task automatic measure(input int len);
        for (int i = 0; i < NCH; i++) begin
            pos_n[i] = 0; neg_n[i] = 0; mt_n[i] = 0; mt_at[i] = 0;
        end
        ovl_n = 0; pk_n = 0; vl_n = 0; mt_nm_n = 0;
        for (int k = 0; k < len; k++) begin
            for (int i = 0; i < NCH; i++) begin
                pos_n[i] += int'(pos_o[i]);
                neg_n[i] += int'(neg_o[i]);
                mt_n[i]  += int'(match_o[i]);
                if (match_o[i] && int'(cnt_o) == cset[i]) mt_at[i]++;
                if (pos_o[i] && neg_o[i]) ovl_n++;
            end
            pk_n    += int'(peak_o);
            vl_n    += int'(valley_o);
            mt_nm_n += int'(match_nm != '0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R12 reset cnt", int'(cnt_o), 0);
        chk("R12 reset pos", int'(pos_o), 0);
        chk("R12 reset neg", int'(neg_o), 0);
        chk("R12 reset events", int'({peak_o, valley_o, match_o}), 0);
    endtask

    task automatic t_triangle();
        configure(5, 0, 2, 3, 9);
        start_run();
        for (int k = 0; k < 20; k++) begin
            int ph = k % 10;
            int exp_cnt = (ph <= 5) ? ph : 10 - ph;
            chk("R1 triangle cnt", int'(cnt_o), exp_cnt);
            chk("R2 peak pulse", int'(peak_o), int'(exp_cnt == 5));
            chk("R2 valley pulse", int'(valley_o), int'(exp_cnt == 0));
            @(negedge clk);
        end
    endtask

    task automatic t_duty();
        configure(20, 2, 5, 10, 15);
        start_run();
        next_valley();
        measure(40);
        chk("R3 R5 pos ch0", pos_n[0], 27);
        chk("R5 pos ch1", pos_n[1], 17);
        chk("R5 pos ch2", pos_n[2], 7);
        chk("R4 R5 neg ch0", neg_n[0], 7);
        chk("R5 neg ch1", neg_n[1], 17);
        chk("R5 neg ch2", neg_n[2], 27);
        chk("R8 overlap", ovl_n, 0);
        chk("R2 peaks per triangle", pk_n, 1);
        chk("R2 valleys per triangle", vl_n, 1);
        chk("R9 match count ch0", mt_n[0], 2);
        chk("R9 match at duty ch2", mt_at[2], 2);
        chk("R9 match disabled variant", mt_nm_n, 0);
    endtask

    task automatic t_hold();
        configure(20, 2, 20, 25, 0);
        start_run();
        next_valley();
        measure(40);
        chk("R6 pos at C=P", pos_n[0], 0);
        chk("R6 neg at C=P", neg_n[0], 40);
        chk("R6 pos at C>P", pos_n[1], 0);
        chk("R6 neg at C>P", neg_n[1], 40);
        chk("R6 pos at C=0", pos_n[2], 0);
        chk("R6 R9 no match at C>=P", mt_n[0] + mt_n[1], 0);
        chk("R9 match at C=0", mt_n[2], 1);
    endtask

    task automatic t_buffer();
        int acc = 0;
        configure(20, 2, 10, 10, 10);
        start_run();
        next_valley();
        write_reg(4, 4);
        while (!valley_o) begin
            acc += int'(pos_o[0]);
            @(negedge clk);
        end
        chk("R10 old duty kept mid-triangle", acc, 17);
        measure(40);
        chk("R10 new duty pos ch0", pos_n[0], 29);
        chk("R10 new duty neg ch0", neg_n[0], 5);
        chk("R10 other channel unchanged", pos_n[1], 17);
    endtask

    task automatic t_dead_long();
        configure(20, 10, 17, 5, 10);
        start_run();
        next_valley();
        measure(40);
        chk("R7 short pulse suppressed pos ch0", pos_n[0], 0);
        chk("R5 neg ch0 dt10", neg_n[0], 23);
        chk("R5 pos ch1 dt10", pos_n[1], 19);
        chk("R7 short gap suppressed neg ch1", neg_n[1], 0);
        chk("R5 pos ch2 dt10", pos_n[2], 9);
        chk("R8 overlap dt10", ovl_n, 0);
    endtask

    task automatic t_dead_running();
        configure(20, 2, 10, 10, 10);
        start_run();
        next_valley();
        write_reg(2, 6);
        next_valley();
        measure(40);
        chk("R11 dead time unchanged while running", pos_n[0], 17);
        write_reg(0, 0);
        start_run();
        next_valley();
        measure(40);
        chk("R11 new dead time after restart pos", pos_n[0], 13);
        chk("R11 new dead time after restart neg", neg_n[0], 13);
    endtask

    task automatic t_stop();
        int act = 0;
        configure(20, 2, 5, 10, 15);
        start_run();
        next_valley();
        repeat (7) @(negedge clk);
        write_reg(0, 0);
        chk("R12 outputs off at stop", int'({pos_o, neg_o}), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            act += int'(cnt_o != '0) + int'(pos_o != '0) + int'(neg_o != '0)
                 + int'(peak_o) + int'(valley_o) + int'(match_o != '0);
        end
        chk("R12 idle while stopped", act, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_triangle();
        t_duty();
        t_hold();
        t_buffer();
        t_dead_long();
        t_dead_running();
        t_stop();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule